// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block holds the coherence state of every line of one private, direct-mapped cache attached to a shared snooping bus. Each line is in one of four states. Modified means the cache holds the only valid copy and memory is stale. Exclusive means no other cache holds the line and memory is current. Shared means other caches may also hold it and memory is current. Invalid means the line holds nothing usable. The controller serves local processor reads and writes. It issues its own bus commands: read, read-for-ownership, address-only invalidate and write-back. It also watches transactions from other caches and answers them in the same cycle with a shared-hit flag and a retry flag.

When a snooped access hits a Modified line, the controller asks the requester to retry. It then pushes the line out to memory with a write-back before any further local request is served, so the requester's second attempt finds memory current. Data storage, the arbiter and memory sit outside this block. The processor holds its request stable until `cpu_done` pulses.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req_valid` and `cpu_done` are low, and no snooped address reports a shared hit.
- R2: A read miss issues a bus read (command code 0) to the requested address. On acknowledge the line becomes Shared if `bus_shared_in` was high and Exclusive otherwise, and `cpu_done` then pulses.
- R3: A write hit on a Shared line issues an address-only invalidate (command code 2) to the requested address. The line becomes Modified when the invalidate is acknowledged.
- R4: A write hit on an Exclusive or Modified line completes with no bus command, and `cpu_done` pulses one cycle after the request is accepted. An Exclusive line becomes Modified.
- R5: A write miss issues a read-for-ownership (command code 1) and installs the line as Modified.
- R6: A miss whose victim line is Modified first writes the victim back (command code 3, address built from the victim tag and the index) and only then fetches the new line. A clean victim is dropped silently.
- R7: A snooped invalidate (code 2) or read-for-ownership (code 1) that hits a valid copy leaves it Invalid. If the copy was Modified, this happens after the push-out.
- R8: A snooped read (code 0) that hits an Exclusive or Shared copy leaves it Shared.
- R9: A snooped read or read-for-ownership that hits a Modified line raises `snp_retry` in the same cycle. A single write-back of that line follows, after which the line is Shared (for a read) or Invalid (for a read-for-ownership).
- R10: `snp_shared` is high in the snoop cycle exactly when the snooped address hits a valid line. A snooped write-back (code 3) changes no state.
- R11: When the bus answers one of the controller's commands with `bus_retry_in`, the same command is issued again to the same address.
- R12: A snoop that touches the line of a local request in the same cycle wins. A local write stalls for that cycle and then acts on the updated state. An invalidate whose line is killed by a snoop, either while outstanding or in its acknowledge cycle, is followed by a read-for-ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Local request present, held until `cpu_done` |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address of the local request |
| cpu_done | output | 1 | One-cycle pulse when the local request completes |
| bus_req_valid | output | 1 | Bus command outstanding |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| bus_req_addr | output | ADDR_W | Line address of the bus command |
| bus_ack | input | 1 | Bus command finished this cycle |
| bus_shared_in | input | 1 | Another cache holds the line (valid with `bus_ack`) |
| bus_retry_in | input | 1 | Command refused, must be reissued (valid with `bus_ack`) |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_cmd | input | 2 | Snooped command, same codes as `bus_req_cmd` |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | Snoop hits a valid local copy (combinational) |
| snp_retry | output | 1 | Snoop hits a Modified copy and must be retried (combinational) |

## Verification
Two functions can act on the same line in the same cycle: a snoop updating a line, and a local write that is either being accepted or having its invalidate acknowledged. The bench provokes this in three ways. It issues a snoop read on the very edge where a write to an Exclusive line is presented. It kills a Shared line while its invalidate is held unacknowledged. It kills a Shared line on the exact edge where the invalidate is acknowledged. It judges each case from the bus command log, which must show the invalidate followed by a read-for-ownership (or an invalidate where the write stalled onto a now-Shared line). It then probes the final state with a snoop read, which must ask for a retry.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BC_READ = 2'd0,
    BC_RFO  = 2'd1,
    BC_INV  = 2'd2,
    BC_WB   = 2'd3
  } bus_cmd_t;

  typedef enum logic [2:0] {
    K_FILL_R,
    K_FILL_W,
    K_UPG,
    K_EVICT,
    K_PUSH
  } op_kind_t;

  typedef enum logic [1:0] {
    F_IDLE,
    F_BUS,
    F_DONE
  } fsm_t;

  // State a valid local copy moves to when another cache's command hits it.
  // A dirty copy hit by a reader stays dirty until the push-out completes.
  function automatic line_st_t snoop_next(line_st_t cur, bus_cmd_t cmd);
    line_st_t nxt;
    nxt = cur;
    case (cmd)
      BC_READ: if (cur == LS_E) nxt = LS_S;
      BC_RFO:  if (cur != LS_M) nxt = LS_I;
      BC_INV:  nxt = LS_I;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

  function automatic logic snoop_wants_retry(line_st_t cur, bus_cmd_t cmd);
    return (cur == LS_M) && ((cmd == BC_READ) || (cmd == BC_RFO));
  endfunction

  function automatic line_st_t fill_state(logic others_hold);
    return others_hold ? LS_S : LS_E;
  endfunction

endpackage

// File: rtl/mesi_tag_array.sv
module mesi_tag_array
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  localparam int TAG_W  = ADDR_W - IDX_W,
  localparam int NLINES = 1 << IDX_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             loc_we,
  input  logic                             loc_tag_we,
  input  logic [IDX_W-1:0]                 loc_idx,
  input  logic [TAG_W-1:0]                 loc_tag,
  input  line_st_t                         loc_st,
  input  logic                             snp_we,
  input  logic [IDX_W-1:0]                 snp_idx,
  input  line_st_t                         snp_st,
  output logic [NLINES-1:0][1:0]           st_q,
  output logic [NLINES-1:0][TAG_W-1:0]     tag_q
);

  // Local writes win over a snoop update to the same line; the controller
  // avoids every local write that could lose coherence information.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        st_q[i]  <= LS_I;
        tag_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NLINES; i++) begin
        if (loc_we && (loc_idx == IDX_W'(i))) begin
          st_q[i] <= loc_st;
          if (loc_tag_we) tag_q[i] <= loc_tag;
        end else if (snp_we && (snp_idx == IDX_W'(i))) begin
          st_q[i] <= snp_st;
        end
      end
    end
  end

endmodule

// File: rtl/mesi_snoop.sv
module mesi_snoop
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  localparam int TAG_W  = ADDR_W - IDX_W,
  localparam int NLINES = 1 << IDX_W
) (
  input  logic                         snp_valid,
  input  bus_cmd_t                     snp_cmd,
  input  logic [ADDR_W-1:0]            snp_addr,
  input  logic [NLINES-1:0][1:0]       st_q,
  input  logic [NLINES-1:0][TAG_W-1:0] tag_q,
  output logic                         s_hit,
  output logic [IDX_W-1:0]             s_idx,
  output logic                         s_we,
  output line_st_t                     s_nst,
  output logic                         s_retry
);

  logic [TAG_W-1:0] s_tag;
  line_st_t         s_cur;

  assign s_idx   = snp_addr[IDX_W-1:0];
  assign s_tag   = snp_addr[ADDR_W-1:IDX_W];
  assign s_cur   = line_st_t'(st_q[s_idx]);
  assign s_hit   = snp_valid && (s_cur != LS_I) && (tag_q[s_idx] == s_tag);
  assign s_nst   = snoop_next(s_cur, snp_cmd);
  assign s_we    = s_hit && (s_nst != s_cur);
  assign s_retry = s_hit && snoop_wants_retry(s_cur, snp_cmd);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_done,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_ack,
  input  logic              bus_shared_in,
  input  logic              bus_retry_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_retry
);

  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int NLINES = 1 << IDX_W;

  logic [NLINES-1:0][1:0]       st_q;
  logic [NLINES-1:0][TAG_W-1:0] tag_q;

  // named internal events
  logic             loc_we, loc_tag_we;
  logic [IDX_W-1:0] loc_idx;
  logic [TAG_W-1:0] loc_tag;
  line_st_t         loc_st;
  logic             s_hit, s_we, s_retry;
  logic [IDX_W-1:0] s_idx;
  line_st_t         s_nst;
  bus_cmd_t         s_cmd;
  logic             collide, pend_clr;

  fsm_t              fsm_q, fsm_d;
  op_kind_t          kind_q, kind_d;
  bus_cmd_t          cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              pend_v_q, pend_inv_q;
  logic [IDX_W-1:0]  pend_idx_q;

  logic [IDX_W-1:0] cpu_idx, op_idx;
  logic [TAG_W-1:0] cpu_tag, op_tag;
  line_st_t         cur_st, op_st, pend_st;
  logic             cur_hit;

  assign s_cmd   = bus_cmd_t'(snp_cmd);
  assign cpu_idx = cpu_req_addr[IDX_W-1:0];
  assign cpu_tag = cpu_req_addr[ADDR_W-1:IDX_W];
  assign op_idx  = addr_q[IDX_W-1:0];
  assign op_tag  = addr_q[ADDR_W-1:IDX_W];
  assign cur_st  = line_st_t'(st_q[cpu_idx]);
  assign op_st   = line_st_t'(st_q[op_idx]);
  assign pend_st = line_st_t'(st_q[pend_idx_q]);
  assign cur_hit = (cur_st != LS_I) && (tag_q[cpu_idx] == cpu_tag);
  assign collide = s_hit && (s_idx == cpu_idx);

  mesi_tag_array #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .loc_we     (loc_we),
    .loc_tag_we (loc_tag_we),
    .loc_idx    (loc_idx),
    .loc_tag    (loc_tag),
    .loc_st     (loc_st),
    .snp_we     (s_we),
    .snp_idx    (s_idx),
    .snp_st     (s_nst),
    .st_q       (st_q),
    .tag_q      (tag_q)
  );

  mesi_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_snoop (
    .snp_valid (snp_valid),
    .snp_cmd   (s_cmd),
    .snp_addr  (snp_addr),
    .st_q      (st_q),
    .tag_q     (tag_q),
    .s_hit     (s_hit),
    .s_idx     (s_idx),
    .s_we      (s_we),
    .s_nst     (s_nst),
    .s_retry   (s_retry)
  );

  assign snp_shared    = s_hit;
  assign snp_retry     = s_retry;
  assign bus_req_valid = (fsm_q == F_BUS);
  assign bus_req_cmd   = cmd_q;
  assign bus_req_addr  = addr_q;
  assign cpu_done      = (fsm_q == F_DONE);

  always_comb begin
    fsm_d      = fsm_q;
    kind_d     = kind_q;
    cmd_d      = cmd_q;
    addr_d     = addr_q;
    loc_we     = 1'b0;
    loc_tag_we = 1'b0;
    loc_idx    = cpu_idx;
    loc_tag    = cpu_tag;
    loc_st     = LS_I;
    pend_clr   = 1'b0;
    case (fsm_q)
      F_IDLE: begin
        if (pend_v_q) begin
          // push-out has priority over any local request
          if (pend_st == LS_M) begin
            fsm_d  = F_BUS;
            kind_d = K_PUSH;
            cmd_d  = BC_WB;
            addr_d = {tag_q[pend_idx_q], pend_idx_q};
          end else begin
            pend_clr = 1'b1;
          end
        end else if (cpu_req_valid && !collide) begin
          if (cur_hit) begin
            if (!cpu_req_write || (cur_st == LS_M)) begin
              fsm_d = F_DONE;
            end else if (cur_st == LS_E) begin
              loc_we = 1'b1;
              loc_st = LS_M;
              fsm_d  = F_DONE;
            end else begin
              fsm_d  = F_BUS;
              kind_d = K_UPG;
              cmd_d  = BC_INV;
              addr_d = cpu_req_addr;
            end
          end else if (cur_st == LS_M) begin
            fsm_d  = F_BUS;
            kind_d = K_EVICT;
            cmd_d  = BC_WB;
            addr_d = {tag_q[cpu_idx], cpu_idx};
          end else begin
            fsm_d  = F_BUS;
            kind_d = cpu_req_write ? K_FILL_W : K_FILL_R;
            cmd_d  = cpu_req_write ? BC_RFO : BC_READ;
            addr_d = cpu_req_addr;
          end
        end
      end
      F_BUS: begin
        if (bus_ack) begin
          loc_idx = op_idx;
          loc_tag = op_tag;
          if (bus_retry_in) begin
            fsm_d = F_IDLE;
          end else begin
            case (kind_q)
              K_PUSH: begin
                loc_we   = 1'b1;
                loc_st   = pend_inv_q ? LS_I : LS_S;
                pend_clr = 1'b1;
                fsm_d    = F_IDLE;
              end
              K_EVICT: begin
                loc_we = 1'b1;
                loc_st = LS_I;
                fsm_d  = F_IDLE;
              end
              K_FILL_R: begin
                loc_we     = 1'b1;
                loc_tag_we = 1'b1;
                loc_st     = fill_state(bus_shared_in);
                fsm_d      = F_DONE;
              end
              K_FILL_W: begin
                loc_we     = 1'b1;
                loc_tag_we = 1'b1;
                loc_st     = LS_M;
                fsm_d      = F_DONE;
              end
              default: begin
                // upgrade completes only if the copy survived every snoop
                if ((op_st == LS_S) && !(s_hit && (s_idx == op_idx))) begin
                  loc_we = 1'b1;
                  loc_st = LS_M;
                  fsm_d  = F_DONE;
                end else begin
                  fsm_d = F_IDLE;
                end
              end
            endcase
          end
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q  <= F_IDLE;
      kind_q <= K_FILL_R;
      cmd_q  <= BC_READ;
      addr_q <= '0;
    end else begin
      fsm_q  <= fsm_d;
      kind_q <= kind_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v_q   <= 1'b0;
      pend_inv_q <= 1'b0;
      pend_idx_q <= '0;
    end else begin
      if (pend_clr) pend_v_q <= 1'b0;
      if (s_retry && (!pend_v_q || pend_clr)) begin
        pend_v_q   <= 1'b1;
        pend_idx_q <= s_idx;
        pend_inv_q <= (s_cmd == BC_RFO);
      end
    end
  end

  // R11: an outstanding command is held unchanged until acknowledged
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_ack) |=> (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_cmd)));

  // R3: an invalidate is only outstanding for a Shared line or one a snoop has killed
  a_r3_inv_on_shared: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && (bus_req_cmd == BC_INV)) |-> ((op_st == LS_S) || (op_st == LS_I)));

  // R6: never fetch into a slot that still holds dirty data
  a_r6_no_fill_over_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && ((bus_req_cmd == BC_READ) || (bus_req_cmd == BC_RFO))) |-> (op_st != LS_M));

  // R2: an accepted read fill leaves the line Exclusive or Shared
  a_r2_fill_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_ack && !bus_retry_in && (kind_q == K_FILL_R))
    |=> ((st_q[$past(op_idx)] == LS_S) || (st_q[$past(op_idx)] == LS_E)));

  // R7: a snooped invalidate hitting a copy leaves it Invalid
  a_r7_snoop_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hit && (s_cmd == BC_INV) && !(loc_we && (loc_idx == s_idx)))
    |=> (st_q[$past(s_idx)] == LS_I));

  // R9: a retry answered while no push-out waits books one
  a_r9_retry_books_pushout: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_retry && !pend_v_q) |=> pend_v_q);

  // R4: completion is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

endmodule

// File: tb/mesi_line_ctrl_tb.sv
module mesi_line_ctrl_tb;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic          cpu_done;
  logic          bus_req_valid;
  logic [1:0]    bus_req_cmd;
  logic [AW-1:0] bus_req_addr;
  logic          bus_ack = 1'b0, bus_shared_in = 1'b0, bus_retry_in = 1'b0;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_shared, snp_retry;

  always #2.5 clk = ~clk;

  mesi_line_ctrl #(.ADDR_W(AW), .IDX_W(2)) u_dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [1:0]    lg_cmd [16];
  logic [AW-1:0] lg_addr[16];
  int  lg_n = 0;
  bit  auto_ack = 1'b1;
  bit  resp_shared = 1'b0;
  int  retry_left = 0;

  // bench state codes: 0 I, 1 S, 2 E, 3 M
  function automatic int after_snoop(int init, int cmd);
    if (init == 0) return 0;
    if (cmd == 3) return init;
    if (cmd == 0) return 1;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle of the bus model: acknowledge a fresh command, log it
  task automatic tick();
    if (bus_req_valid && !bus_ack && auto_ack) begin
      if (lg_n < 16) begin
        lg_cmd[lg_n]  = bus_req_cmd;
        lg_addr[lg_n] = bus_req_addr;
      end
      lg_n++;
      bus_ack       = 1'b1;
      bus_shared_in = resp_shared;
      bus_retry_in  = (retry_left > 0);
      if (retry_left > 0) retry_left--;
    end else begin
      bus_ack = 1'b0; bus_shared_in = 1'b0; bus_retry_in = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic start_cpu(bit w, logic [AW-1:0] a);
    while (cpu_done) tick();
    cpu_req_valid = 1'b1; cpu_req_write = w; cpu_req_addr = a;
  endtask

  task automatic finish_cpu(output int cyc);
    cyc = 0;
    while (!cpu_done && cyc < 200) begin tick(); cyc++; end
    cpu_req_valid = 1'b0;
    bus_ack = 1'b0; bus_shared_in = 1'b0; bus_retry_in = 1'b0;
  endtask

  task automatic cpu_op(bit w, logic [AW-1:0] a, output int cyc);
    start_cpu(w, a);
    finish_cpu(cyc);
  endtask

  task automatic snoop(int cmd, logic [AW-1:0] a, output bit sh, output bit rt);
    snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_addr = a;
    #1;
    sh = snp_shared; rt = snp_retry;
    tick();
    snp_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) tick();
    bus_ack = 1'b0; bus_shared_in = 1'b0; bus_retry_in = 1'b0;
  endtask

  task automatic setup(int st, logic [AW-1:0] a);
    bit sh, rt;
    int cyc;
    snoop(2, a, sh, rt);
    idle(2);
    case (st)
      0: begin resp_shared = 0; cpu_op(0, a, cyc); snoop(2, a, sh, rt); end
      1: begin resp_shared = 1; cpu_op(0, a, cyc); end
      2: begin resp_shared = 0; cpu_op(0, a, cyc); end
      default: begin resp_shared = 0; cpu_op(1, a, cyc); end
    endcase
    resp_shared = 0;
    idle(2);
    lg_n = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit sh, rt;
    int cyc;
    logic [AW-1:0] a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(!bus_req_valid && !cpu_done, "R1 idle outputs", int'(bus_req_valid), 0);
    for (int i = 0; i < 8; i++) begin
      snoop(3, 8'(i * 37), sh, rt);
      chk(!sh && !rt, "R1 no line valid", int'(sh), 0);
    end

    // R2: read miss -> READ, fill Exclusive when nobody else holds it
    lg_n = 0;
    cpu_op(0, 8'h41, cyc);
    chk(lg_n == 1 && lg_cmd[0] == 2'd0 && lg_addr[0] == 8'h41, "R2 read miss cmd", int'(lg_cmd[0]), 0);
    lg_n = 0;
    cpu_op(1, 8'h41, cyc);
    chk(lg_n == 0, "R2 fill state E (silent write)", lg_n, 0);

    // R5: write miss -> RFO, line Modified
    lg_n = 0;
    cpu_op(1, 8'h96, cyc);
    chk(lg_n == 1 && lg_cmd[0] == 2'd1 && lg_addr[0] == 8'h96, "R5 write miss RFO", int'(lg_cmd[0]), 1);
    snoop(0, 8'h96, sh, rt);
    chk(rt == 1'b1, "R5 line Modified (retry)", int'(rt), 1);
    idle(6);

    // R11: command refused twice is reissued unchanged
    a = 8'h5b;
    setup(0, a);
    retry_left = 2;
    cpu_op(0, a, cyc);
    chk(lg_n == 3, "R11 reissue count", lg_n, 3);
    for (int i = 0; i < 3; i++)
      chk(lg_cmd[i] == 2'd0 && lg_addr[i] == a, "R11 same command", int'(lg_addr[i]), int'(a));

    // near-exhaustive sweep: line x initial state x snooped command x probe mode
    for (int idx = 0; idx < 4; idx++)
      for (int init = 0; init < 4; init++)
        for (int cmd = 0; cmd < 4; cmd++)
          for (int pass = 0; pass < 2; pass++) begin
            int fin;
            bit exp_rt;
            a = {6'(6'h05 + idx), 2'(idx)};
            b = {6'(6'h05 + idx) ^ 6'h2a, 2'(idx)};
            setup(init, a);
            snoop(cmd, a, sh, rt);
            exp_rt = (init == 3) && (cmd <= 1);
            chk(sh == (init != 0), "R10 shared flag", int'(sh), int'(init != 0));
            chk(rt == exp_rt, "R9 retry flag", int'(rt), int'(exp_rt));
            idle(6);
            if (exp_rt)
              chk(lg_n == 1 && lg_cmd[0] == 2'd3 && lg_addr[0] == a, "R9 single push-out", lg_n, 1);
            else
              chk(lg_n == 0, "R10 no bus traffic", lg_n, 0);
            fin = after_snoop(init, cmd);
            lg_n = 0;
            if (pass == 0) begin
              snoop(3, a, sh, rt);
              chk(sh == (fin != 0), "R7 validity after snoop", int'(sh), int'(fin != 0));
              if (fin != 0) begin
                lg_n = 0;
                cpu_op(1, a, cyc);
                if (fin == 1)
                  chk(lg_n == 1 && lg_cmd[0] == 2'd2 && lg_addr[0] == a, "R8 shared -> invalidate", lg_n, 1);
                else begin
                  chk(lg_n == 0, "R4 silent write hit", lg_n, 0);
                  chk(cyc == 1, "R4 one-cycle completion", cyc, 1);
                end
              end
            end else begin
              cpu_op(0, b, cyc);
              if (fin == 3) begin
                chk(lg_n == 2 && lg_cmd[0] == 2'd3 && lg_addr[0] == a, "R6 dirty victim written back", lg_n, 2);
                chk(lg_cmd[1] == 2'd0 && lg_addr[1] == b, "R6 fill after write-back", int'(lg_addr[1]), int'(b));
              end else
                chk(lg_n == 1 && lg_cmd[0] == 2'd0 && lg_addr[0] == b, "R6 clean victim silent", lg_n, 1);
            end
            idle(2);
          end

    // R12 case A: invalidate outstanding, snoop kills the copy meanwhile
    a = 8'h23;
    setup(1, a);
    auto_ack = 0;
    start_cpu(1, a);
    idle(3);
    chk(bus_req_valid && bus_req_cmd == 2'd2 && bus_req_addr == a, "R3 invalidate outstanding", int'(bus_req_cmd), 2);
    snoop(2, a, sh, rt);
    chk(sh && !rt, "R12 kill of shared copy", int'(sh), 1);
    auto_ack = 1;
    finish_cpu(cyc);
    chk(lg_n == 2 && lg_cmd[0] == 2'd2 && lg_cmd[1] == 2'd1, "R12 invalidate then RFO", int'(lg_cmd[1]), 1);
    snoop(0, a, sh, rt);
    chk(rt, "R12 ends Modified", int'(rt), 1);
    idle(6);

    // R12 case B: kill lands on the acknowledge edge
    setup(1, a);
    auto_ack = 0;
    start_cpu(1, a);
    idle(2);
    auto_ack = 1;
    snoop(2, a, sh, rt);
    finish_cpu(cyc);
    chk(lg_n == 2 && lg_cmd[0] == 2'd2 && lg_cmd[1] == 2'd1, "R12 same-edge kill", int'(lg_n), 2);
    snoop(0, a, sh, rt);
    chk(rt, "R12 same-edge ends Modified", int'(rt), 1);
    idle(6);

    // R12 case C: snoop read on the edge a write hits an Exclusive line
    setup(2, a);
    start_cpu(1, a);
    snoop(0, a, sh, rt);
    chk(sh && !rt, "R12 snoop sees Exclusive", int'(rt), 0);
    finish_cpu(cyc);
    chk(lg_n == 1 && lg_cmd[0] == 2'd2 && lg_addr[0] == a, "R12 stalled write upgrades", lg_n, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule